// File: doc/BRIEF.md
# Byte Rotate and Shift Unit

This block rotates or shifts one data byte by a single position. The kind of move is chosen by a 3-bit operation code. The operation code, the operand and the incoming flag byte are sampled on a clock edge. One edge later the block presents the moved byte and a fresh flag byte. The carry input of the through-carry rotates is bit 0 of the incoming flag byte.

Six codes do real work: two circular rotates, two rotates through carry, a left shift that fills with zero, and a right shift that keeps the sign bit. Every one of them rebuilds the whole flag byte from its result. The remaining two codes pass the operand through, and the incoming flag byte comes out untouched.

The flag byte layout is fixed as follows:

| Bit | Flag |
|-----|------|
| 7 | sign |
| 6 | zero |
| 5 | copy of result bit 5 |
| 4 | half carry |
| 3 | copy of result bit 3 |
| 2 | parity |
| 1 | subtract |
| 0 | carry |

Top module: `rotshift_unit`

## Requirements
- R1: Code 0 (circular left): the result is the operand shifted left with old bit 7 placed in bit 0, and carry (flag bit 0) takes old bit 7.
- R2: Code 2 (left through carry): the result is the operand shifted left with incoming flag bit 0 placed in bit 0, and carry takes old bit 7.
- R3: Code 1 (circular right): the result is the operand shifted right with old bit 0 placed in bit 7, and carry takes old bit 0.
- R4: Code 3 (right through carry): the result is the operand shifted right with incoming flag bit 0 placed in bit 7, and carry takes old bit 0.
- R5: Code 4 (left shift): bit 0 of the result is zero, and carry takes old bit 7.
- R6: Code 5 (right shift): bit 7 of the result equals old bit 7, and carry takes old bit 0.
- R7: For codes 0 to 5, half carry (flag bit 4) and subtract (flag bit 1) are both zero.
- R8: For codes 0 to 5, parity (flag bit 2) is one exactly when the result holds an even number of ones.
- R9: For codes 0 to 5, sign (flag bit 7) equals result bit 7, and zero (flag bit 6) is one exactly when the result is zero.
- R10: For codes 0 to 5, flag bits 5 and 3 copy result bits 5 and 3.
- R11: Codes 6 and 7 return the operand as the result and the incoming flag byte unchanged.
- R12: While reset (active low) is held, both the result and the flag byte read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| operand_i | input | DATA_W | Byte to rotate or shift |
| flags_i | input | 8 | Incoming flag byte; bit 0 is the carry in |
| result_o | output | DATA_W | Registered result |
| flags_o | output | 8 | Registered flag byte |

## Verification
The bench builds the block with DATA_W at its default of 8. At that width every operand value can be applied under every operation code, with the carry in both set and clear. This covers each wrap-around bit, the zero result and every parity case. For the two pass-through codes, the incoming flag byte is also swept, so every flag pattern is shown to survive unchanged.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int FLAG_W = 8;
    localparam int FLG_C  = 0;
    localparam int FLG_N  = 1;
    localparam int FLG_PV = 2;
    localparam int FLG_F3 = 3;
    localparam int FLG_H  = 4;
    localparam int FLG_F5 = 5;
    localparam int FLG_Z  = 6;
    localparam int FLG_S  = 7;

    typedef enum logic [2:0] {
        OP_ROL_CIRC = 3'd0,
        OP_ROR_CIRC = 3'd1,
        OP_ROL_THRU = 3'd2,
        OP_ROR_THRU = 3'd3,
        OP_SHL_ZERO = 3'd4,
        OP_SHR_SIGN = 3'd5,
        OP_SPARE_A  = 3'd6,
        OP_SPARE_B  = 3'd7
    } rs_op_e;
endpackage

// File: rtl/rs_shift_core.sv
module rs_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    output logic [DATA_W-1:0] dout,
    output logic              cout,
    output logic              active
);
    import rs_pkg::*;
    localparam int MSB = DATA_W - 1;

    always_comb begin
        dout   = din;
        cout   = cin;
        active = 1'b1;
        case (rs_op_e'(op))
            OP_ROL_CIRC: begin dout = {din[MSB-1:0], din[MSB]}; cout = din[MSB]; end
            OP_ROR_CIRC: begin dout = {din[0], din[MSB:1]};     cout = din[0];   end
            OP_ROL_THRU: begin dout = {din[MSB-1:0], cin};      cout = din[MSB]; end
            OP_ROR_THRU: begin dout = {cin, din[MSB:1]};        cout = din[0];   end
            OP_SHL_ZERO: begin dout = {din[MSB-1:0], 1'b0};     cout = din[MSB]; end
            OP_SHR_SIGN: begin dout = {din[MSB], din[MSB:1]};   cout = din[0];   end
            default:     active = 1'b0;
        endcase
    end
endmodule

// File: rtl/rs_flag_gen.sv
module rs_flag_gen #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]        res,
    input  logic                     carry,
    output logic [rs_pkg::FLAG_W-1:0] flags
);
    import rs_pkg::*;

    always_comb begin
        flags         = '0;
        flags[FLG_S]  = res[DATA_W-1];
        flags[FLG_Z]  = (res == '0);
        flags[FLG_F5] = res[5];
        flags[FLG_F3] = res[3];
        flags[FLG_PV] = ~^res;
        flags[FLG_H]  = 1'b0;
        flags[FLG_N]  = 1'b0;
        flags[FLG_C]  = carry;
    end
endmodule

// File: rtl/rotshift_unit.sv
module rotshift_unit #(
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [2:0]                op_i,
    input  logic [DATA_W-1:0]         operand_i,
    input  logic [rs_pkg::FLAG_W-1:0] flags_i,
    output logic [DATA_W-1:0]         result_o,
    output logic [rs_pkg::FLAG_W-1:0] flags_o
);
    import rs_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [FLAG_W-1:0] flg;
    } rs_state_t;

    rs_state_t state_d, state_q;

    logic [DATA_W-1:0] core_res;
    logic              core_c;
    logic              core_act;
    logic [FLAG_W-1:0] gen_flg;

    rs_shift_core #(.DATA_W(DATA_W)) u_core (
        .op     (op_i),
        .din    (operand_i),
        .cin    (flags_i[FLG_C]),
        .dout   (core_res),
        .cout   (core_c),
        .active (core_act)
    );

    rs_flag_gen #(.DATA_W(DATA_W)) u_flags (
        .res   (core_res),
        .carry (core_c),
        .flags (gen_flg)
    );

    always_comb begin
        state_d.res = core_res;
        state_d.flg = core_act ? gen_flg : flags_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign result_o = state_q.res;
    assign flags_o  = state_q.flg;
endmodule

// File: rtl/rotshift_unit_chk.sv
module rotshift_unit_chk #(
    parameter int DATA_W = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [2:0]                op_i,
    input logic [DATA_W-1:0]         operand_i,
    input logic [rs_pkg::FLAG_W-1:0] flags_i,
    input logic [DATA_W-1:0]         result_o,
    input logic [rs_pkg::FLAG_W-1:0] flags_o
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    AST_ROL_CIRC: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd0) |-> (result_o[0] == $past(operand_i[DATA_W-1]) && flags_o[0] == $past(operand_i[DATA_W-1]))); // R1
    AST_ROR_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd3) |-> (result_o[DATA_W-1] == $past(flags_i[0]) && flags_o[0] == $past(operand_i[0]))); // R4
    AST_SHR_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) == 3'd5) |-> (result_o[DATA_W-1] == $past(operand_i[DATA_W-1]))); // R6
    AST_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) < 3'd6) |-> (flags_o[4] == 1'b0 && flags_o[1] == 1'b0)); // R7
    AST_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) < 3'd6) |-> (flags_o[2] == ($countones(result_o) % 2 == 0))); // R8
    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) < 3'd6) |-> (flags_o[7] == result_o[DATA_W-1] && flags_o[6] == (result_o == '0))); // R9
    AST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op_i) >= 3'd6) |-> (result_o == $past(operand_i) && flags_o == $past(flags_i))); // R11
    AST_RESET_VAL: assert property (@(posedge clk) !rst_n |-> (result_o == '0 && flags_o == '0)); // R12
endmodule

bind rotshift_unit rotshift_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .operand_i (operand_i),
    .flags_i   (flags_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/rotshift_unit_test.sv
module rotshift_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    op_i = '0;
    logic [DW-1:0] operand_i = '0;
    logic [7:0]    flags_i = '0;
    logic [DW-1:0] result_o;
    logic [7:0]    flags_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    rotshift_unit #(.DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) % 2;
        return n;
    endfunction

    task automatic apply(input int op, input int a, input int fl);
        int er, ec, cin, ef;
        string tag;
        @(negedge clk);
        op_i = op[2:0]; operand_i = a[7:0]; flags_i = fl[7:0];
        @(negedge clk);
        cin = fl % 2;
        er = a; ec = 0; tag = "R11";
        case (op)
            0: begin er = (a * 2) % 256 + a / 128; ec = a / 128; tag = "R1"; end
            1: begin er = a / 2 + (a % 2) * 128;   ec = a % 2;   tag = "R3"; end
            2: begin er = (a * 2) % 256 + cin;     ec = a / 128; tag = "R2"; end
            3: begin er = a / 2 + cin * 128;       ec = a % 2;   tag = "R4"; end
            4: begin er = (a * 2) % 256;           ec = a / 128; tag = "R5"; end
            5: begin er = a / 2 + (a / 128) * 128; ec = a % 2;   tag = "R6"; end
            default: ;
        endcase
        if (op >= 6) begin
            chk(result_o == er[7:0] && flags_o == fl[7:0], "R11",
                {result_o, flags_o}, er * 256 + fl);
        end else begin
            chk(result_o == er[7:0] && flags_o[0] == ec[0], tag,
                {result_o, 7'd0, flags_o[0]}, er * 256 + ec);
            chk(flags_o[4] == 1'b0 && flags_o[1] == 1'b0, "R7", flags_o, 0);
            ef = (ones(er) % 2 == 0) ? 1 : 0;
            chk(flags_o[2] == ef[0], "R8", flags_o[2], ef);
            chk(flags_o[7] == er[7] && flags_o[6] == (er == 0), "R9",
                flags_o[7:6], er[7] * 2 + ((er == 0) ? 1 : 0));
            chk(flags_o[5] == er[5] && flags_o[3] == er[3], "R10",
                {flags_o[5], flags_o[3]}, er[5] * 2 + er[3]);
        end
    endtask

    initial begin
        op_i = 3'd2; operand_i = 8'hA5; flags_i = 8'hFF;
        repeat (3) @(negedge clk);
        chk(result_o == '0 && flags_o == '0, "R12", {result_o, flags_o}, 0);
        rst_n = 1'b1;
        for (int op = 0; op < 6; op++)
            for (int a = 0; a < 256; a++)
                for (int c = 0; c < 2; c++)
                    apply(op, a, c | ((a * 37) & 8'hFE));
        for (int op = 6; op < 8; op++)
            for (int a = 0; a < 256; a++)
                apply(op, a, a ^ 8'h5A);
        for (int f = 0; f < 256; f++)
            apply(6 + f % 2, 8'h3C, f);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule